// File: doc/BRIEF.md
# Reconfigurable Integer/Complex Multiplier

This block is the multiply datapath of a processor execute stage. Four half-width signed multipliers work on the upper and lower halves of two source words. A 2-bit mode input selects how their results are combined. In integer mode the four partial products are added at their shifted weights, which gives the full double-width signed product. In complex mode each source word is read as a packed complex sample: the low half is the in-phase part and the high half is the quadrature part. The block then returns the real and imaginary parts of the complex product. A third mode returns the sum of the like-index products, which is the squared magnitude when both operands are equal. The last mode drives zero.

Results keep the full width of a half-width product, so the low-order bits of narrow signals are not lost. Nothing saturates. The one combination that overflows the 32-bit range wraps around.

An optional output register turns the datapath into a one-cycle pipeline stage. Without it, the path is purely combinational.

Top module: `rcm_mul`

## Requirements
- R1: With mode_sel = 2'b00, result equals the signed product src_a × src_b over all 64 bits, with both operands taken as signed 32-bit integers.
- R2: In the complex modes (2'b01 and 2'b10), bits [15:0] of each operand are the signed in-phase part (I1 from src_a, I2 from src_b) and bits [31:16] are the signed quadrature part (Q1, Q2).
- R3: With mode_sel = 2'b01, result[31:0] equals I1·I2 − Q1·Q2 modulo 2^32.
- R4: With mode_sel = 2'b01, result[63:32] equals I1·Q2 + Q1·I2 modulo 2^32.
- R5: With mode_sel = 2'b10, result[31:0] equals I1·I2 + Q1·Q2 modulo 2^32 and result[63:32] is zero. With src_a = src_b, this is the squared magnitude I² + Q².
- R6: With mode_sel = 2'b11, result is zero for every operand pair.
- R7: When all four 16-bit parts equal −32768, the mode 2'b01 imaginary part and the mode 2'b10 sum wrap to 32'h8000_0000, and the mode 2'b01 real part is zero.
- R8: With OUT_REG = 1, result shows the value for inputs presented before a rising clock edge from that edge onward, and holds its previous value until then. With OUT_REG = 0, result follows the inputs within the same cycle.
- R9: With OUT_REG = 1, driving rst_n low clears result to zero at once, without waiting for a clock edge.
- R10: R1 to R6 hold for any half width HALF_W ≥ 3. The field boundaries scale with it: the in-phase part is bits [HALF_W-1:0], and the real part is the low 2·HALF_W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 integer, 01 complex, 10 power sum, 11 zero |
| src_a | input | 2·HALF_W | First operand (integer, or I1 low / Q1 high) |
| src_b | input | 2·HALF_W | Second operand (integer, or I2 low / Q2 high) |
| result | output | 4·HALF_W | Product, or imaginary part high and real part low |

## Verification
The real part and the imaginary part come out of the same cycle. Each is built from a different pair of the four shared partial products, and the power mode reuses the real-part adder with the sign of one term flipped. The bench therefore drives operand pairs whose halves take the sign and range extremes in every combination, together with random pairs. It compares the two halves of the result separately against an arithmetic model, so a mixed-up product pairing or a wrong negation shows up in the half it affects. A second instance with 3-bit halves is swept over every operand pair in every mode. The pipeline stage is judged by sampling the result both just before and just after the capturing edge.

// File: rtl/rcm_pkg.sv
`timescale 1ns/1ps
package rcm_pkg;
   typedef enum logic [1:0] {
      RCM_INT  = 2'b00,
      RCM_CPLX = 2'b01,
      RCM_PWR  = 2'b10,
      RCM_NONE = 2'b11
   } rcm_mode_e;

   // order of partial products inside the array: {src_a half, src_b half}
   localparam int RCM_PP_LL = 0;
   localparam int RCM_PP_LH = 1;
   localparam int RCM_PP_HL = 2;
   localparam int RCM_PP_HH = 3;
   localparam int RCM_NUM_PP = 4;
endpackage

// File: rtl/rcm_mul_cell.sv
`timescale 1ns/1ps
module rcm_mul_cell #(
   parameter int HALF_W = 16,
   localparam int PP_W = 2*HALF_W + 2
) (
   input  logic [HALF_W-1:0]      x_i,
   input  logic                   x_signed_i,
   input  logic [HALF_W-1:0]      y_i,
   input  logic                   y_signed_i,
   output logic signed [PP_W-1:0] p_o
);
   logic signed [HALF_W:0] x_ext;
   logic signed [HALF_W:0] y_ext;

   // one extra bit lets the same cell take an unsigned low half or a signed one
   assign x_ext = {x_signed_i & x_i[HALF_W-1], x_i};
   assign y_ext = {y_signed_i & y_i[HALF_W-1], y_i};
   assign p_o   = x_ext * y_ext;
endmodule

// File: rtl/rcm_pp_array.sv
`timescale 1ns/1ps
module rcm_pp_array
   import rcm_pkg::*;
#(
   parameter int HALF_W = 16,
   localparam int OP_W = 2*HALF_W,
   localparam int PP_W = 2*HALF_W + 2
) (
   input  logic [OP_W-1:0]        src_a_i,
   input  logic [OP_W-1:0]        src_b_i,
   input  logic                   lo_signed_i,
   output logic signed [PP_W-1:0] pp_ll_o,
   output logic signed [PP_W-1:0] pp_lh_o,
   output logic signed [PP_W-1:0] pp_hl_o,
   output logic signed [PP_W-1:0] pp_hh_o
);
   logic signed [PP_W-1:0] pp [RCM_NUM_PP];

   for (genvar k = 0; k < RCM_NUM_PP; k++) begin : g_cell
      localparam bit A_HI = k[1];
      localparam bit B_HI = k[0];
      logic [HALF_W-1:0] xa;
      logic [HALF_W-1:0] yb;
      logic              xs;
      logic              ys;

      if (A_HI) begin : g_ahi
         assign xa = src_a_i[OP_W-1:HALF_W];
         assign xs = 1'b1;
      end else begin : g_alo
         assign xa = src_a_i[HALF_W-1:0];
         assign xs = lo_signed_i;
      end

      if (B_HI) begin : g_bhi
         assign yb = src_b_i[OP_W-1:HALF_W];
         assign ys = 1'b1;
      end else begin : g_blo
         assign yb = src_b_i[HALF_W-1:0];
         assign ys = lo_signed_i;
      end

      rcm_mul_cell #(.HALF_W(HALF_W)) i_cell (
         .x_i        (xa),
         .x_signed_i (xs),
         .y_i        (yb),
         .y_signed_i (ys),
         .p_o        (pp[k])
      );
   end

   assign pp_ll_o = pp[RCM_PP_LL];
   assign pp_lh_o = pp[RCM_PP_LH];
   assign pp_hl_o = pp[RCM_PP_HL];
   assign pp_hh_o = pp[RCM_PP_HH];
endmodule

// File: rtl/rcm_combine.sv
`timescale 1ns/1ps
module rcm_combine
   import rcm_pkg::*;
#(
   parameter int HALF_W       = 16,
   parameter bit SHARE_ADDERS = 1'b1,
   localparam int PART_W = 2*HALF_W,
   localparam int RES_W  = 4*HALF_W,
   localparam int PP_W   = 2*HALF_W + 2,
   localparam int EXT_W  = RES_W - PP_W
) (
   input  rcm_mode_e              mode_i,
   input  logic signed [PP_W-1:0] pp_ll_i,
   input  logic signed [PP_W-1:0] pp_lh_i,
   input  logic signed [PP_W-1:0] pp_hl_i,
   input  logic signed [PP_W-1:0] pp_hh_i,
   output logic [RES_W-1:0]       res_o
);
   logic [RES_W-1:0]  w_ll;
   logic [RES_W-1:0]  w_lh;
   logic [RES_W-1:0]  w_hl;
   logic [RES_W-1:0]  w_hh;
   logic [RES_W-1:0]  cross_sum;
   logic [RES_W-1:0]  int_res;
   logic [PART_W-1:0] re_part;
   logic [PART_W-1:0] im_part;
   logic [PART_W-1:0] pwr_part;

   assign w_ll = {{EXT_W{pp_ll_i[PP_W-1]}}, pp_ll_i};
   assign w_lh = {{EXT_W{pp_lh_i[PP_W-1]}}, pp_lh_i};
   assign w_hl = {{EXT_W{pp_hl_i[PP_W-1]}}, pp_hl_i};
   assign w_hh = {{EXT_W{pp_hh_i[PP_W-1]}}, pp_hh_i};

   // the two cross products share weight 2^HALF_W in integer mode
   assign cross_sum = w_hl + w_lh;
   assign int_res   = w_ll + (cross_sum << HALF_W) + (w_hh << PART_W);

   if (SHARE_ADDERS) begin : g_shared
      logic              do_sub;
      logic [PART_W-1:0] hh_term;
      logic [PART_W-1:0] rp_sum;

      // imaginary part reuses the integer cross adder
      assign im_part = cross_sum[PART_W-1:0];
      // one adder serves real and power: invert plus carry-in negates hh
      assign do_sub  = (mode_i != RCM_PWR);
      assign hh_term = do_sub ? ~pp_hh_i[PART_W-1:0] : pp_hh_i[PART_W-1:0];
      assign rp_sum  = pp_ll_i[PART_W-1:0] + hh_term + PART_W'(do_sub);
      assign re_part  = rp_sum;
      assign pwr_part = rp_sum;
   end else begin : g_separate
      logic [PART_W-1:0] hh_neg;

      assign im_part  = pp_hl_i[PART_W-1:0] + pp_lh_i[PART_W-1:0];
      assign hh_neg   = ~pp_hh_i[PART_W-1:0] + PART_W'(1);
      assign re_part  = pp_ll_i[PART_W-1:0] + hh_neg;
      assign pwr_part = pp_ll_i[PART_W-1:0] + pp_hh_i[PART_W-1:0];
   end

   always_comb begin
      unique case (mode_i)
         RCM_INT:  res_o = int_res;
         RCM_CPLX: res_o = {im_part, re_part};
         RCM_PWR:  res_o = {{PART_W{1'b0}}, pwr_part};
         default:  res_o = '0;
      endcase
   end
endmodule

// File: rtl/rcm_out_stage.sv
`timescale 1ns/1ps
module rcm_out_stage #(
   parameter int W       = 64,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o <= '0;
         else        q_o <= d_i;
      end
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign q_o = d_i;
   end
endmodule

// File: rtl/rcm_mul.sv
`timescale 1ns/1ps
module rcm_mul
   import rcm_pkg::*;
#(
   parameter int HALF_W       = 16,
   parameter bit OUT_REG      = 1'b1,
   parameter bit SHARE_ADDERS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode_sel,
   input  logic [2*HALF_W-1:0] src_a,
   input  logic [2*HALF_W-1:0] src_b,
   output logic [4*HALF_W-1:0] result
);
   localparam int OP_W   = 2*HALF_W;
   localparam int PART_W = 2*HALF_W;
   localparam int RES_W  = 4*HALF_W;
   localparam int PP_W   = 2*HALF_W + 2;

   if (HALF_W < 3) begin : g_bad_width
      $error("rcm_mul: HALF_W must be at least 3");
   end

   rcm_mode_e              mode;
   logic                   lo_signed;
   logic signed [PP_W-1:0] pp_ll;
   logic signed [PP_W-1:0] pp_lh;
   logic signed [PP_W-1:0] pp_hl;
   logic signed [PP_W-1:0] pp_hh;
   logic [RES_W-1:0]       comb_res;

   assign mode      = rcm_mode_e'(mode_sel);
   // low halves are unsigned digits of a wide integer, signed I parts otherwise
   assign lo_signed = (mode != RCM_INT);

   rcm_pp_array #(.HALF_W(HALF_W)) i_pp (
      .src_a_i     (src_a),
      .src_b_i     (src_b),
      .lo_signed_i (lo_signed),
      .pp_ll_o     (pp_ll),
      .pp_lh_o     (pp_lh),
      .pp_hl_o     (pp_hl),
      .pp_hh_o     (pp_hh)
   );

   rcm_combine #(.HALF_W(HALF_W), .SHARE_ADDERS(SHARE_ADDERS)) i_comb (
      .mode_i  (mode),
      .pp_ll_i (pp_ll),
      .pp_lh_i (pp_lh),
      .pp_hl_i (pp_hl),
      .pp_hh_i (pp_hh),
      .res_o   (comb_res)
   );

   rcm_out_stage #(.W(RES_W), .OUT_REG(OUT_REG)) i_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (comb_res),
      .q_o   (result)
   );

   // ---------------- assertions ----------------
   logic [PART_W-1:0] i1_ext;
   logic [PART_W-1:0] q1_ext;
   assign i1_ext = {{HALF_W{src_a[HALF_W-1]}}, src_a[HALF_W-1:0]};
   assign q1_ext = {{HALF_W{src_a[OP_W-1]}}, src_a[OP_W-1:HALF_W]};

   AST_INT_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RCM_INT && (src_a == '0 || src_b == '0)) |-> (comb_res == '0)); // R1

   AST_CPLX_UNIT_RHS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RCM_CPLX && src_b == OP_W'(1)) |-> (comb_res == {q1_ext, i1_ext})); // R3

   AST_PWR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RCM_PWR) |-> (comb_res[RES_W-1:PART_W] == '0)); // R5

   if (OUT_REG) begin : g_ast_reg
      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == RCM_NONE) |=> (result == '0)); // R6
      AST_REG_TRACKS_INT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == RCM_INT && src_a == '0) |=> (result == '0)); // R8
   end else begin : g_ast_comb
      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == RCM_NONE) |-> (result == '0)); // R6
   end
endmodule

// File: tb/test_rcm_mul.sv
`timescale 1ns/1ps
module test_rcm_mul;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_sel = 2'b00;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [63:0] result;

   logic [1:0]  s_mode = 2'b00;
   logic [5:0]  s_a = '0;
   logic [5:0]  s_b = '0;
   logic [11:0] s_res;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   rcm_mul i_rcm_mul (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .src_a(src_a), .src_b(src_b), .result(result)
   );

   rcm_mul #(.HALF_W(3), .OUT_REG(1'b0)) i_rcm_mul_small (
      .clk(clk), .rst_n(rst_n), .mode_sel(s_mode),
      .src_a(s_a), .src_b(s_b), .result(s_res)
   );

   function automatic longint sx(longint v, int w);
      longint one = 1;
      return (v >= (one << (w-1))) ? v - (one << w) : v;
   endfunction

   function automatic logic [63:0] ref_fn(int hw, logic [1:0] md, longint a, longint b);
      longint one = 1;
      longint hm  = (one << hw) - 1;
      longint pm  = (one << (2*hw)) - 1;
      longint la  = sx(a & hm, hw);
      longint ha  = sx((a >> hw) & hm, hw);
      longint lb  = sx(b & hm, hw);
      longint hb  = sx((b >> hw) & hm, hw);
      longint r;
      case (md)
         2'b00: begin
            r = sx(a & pm, 2*hw) * sx(b & pm, 2*hw);
            if (hw < 16) r = r & ((one << (4*hw)) - 1);
         end
         2'b01: r = (((la*hb + ha*lb) & pm) << (2*hw)) | ((la*lb - ha*hb) & pm);
         2'b10: r = (la*lb + ha*hb) & pm;
         default: r = 0;
      endcase
      return 64'(r);
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive at a falling edge, compare after the capturing rising edge
   task automatic apply(logic [1:0] md, logic [31:0] a, logic [31:0] b);
      logic [63:0] e;
      @(negedge clk);
      mode_sel = md; src_a = a; src_b = b;
      e = ref_fn(16, md, longint'(a), longint'(b));
      @(negedge clk);
      case (md)
         2'b00: check("R1 integer product", result, e);
         2'b01: begin
            check("R3 real part (R2 layout)", {32'h0, result[31:0]}, {32'h0, e[31:0]});
            check("R4 imaginary part", {32'h0, result[63:32]}, {32'h0, e[63:32]});
         end
         2'b10: check("R5 power sum", result, e);
         default: check("R6 zero mode", result, 64'h0);
      endcase
   endtask

   initial begin
      #3000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] corner [8];
      corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'hFFFF; corner[3] = 16'h7FFF;
      corner[4] = 16'h8000; corner[5] = 16'h0002; corner[6] = 16'hFFFE; corner[7] = 16'h1234;

      // R9 reset state
      src_a = 32'h1234_5678; src_b = 32'h9ABC_DEF0;
      repeat (3) @(negedge clk);
      check("R9 reset value", result, 64'h0);
      rst_n = 1'b1;

      // R10 exhaustive sweep of the narrow combinational instance
      for (int m = 0; m < 4; m++)
         for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++) begin
               s_mode = 2'(m); s_a = 6'(a); s_b = 6'(b);
               #1;
               check("R10 narrow sweep", {52'h0, s_res}, ref_fn(3, 2'(m), longint'(a), longint'(b)));
            end

      // R1..R6 over corner half-words in every combination
      for (int m = 0; m < 4; m++)
         for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++)
               apply(2'(m), {corner[i/8], corner[i%8]}, {corner[j/8], corner[j%8]});

      // random operands
      for (int n = 0; n < 1500; n++)
         apply(2'(n % 4), $urandom, $urandom);

      // R7 wrap corner
      apply(2'b01, 32'h8000_8000, 32'h8000_8000);
      check("R7 complex imag wraps", {32'h0, result[63:32]}, 64'h8000_0000);
      check("R7 complex real zero", {32'h0, result[31:0]}, 64'h0);
      apply(2'b10, 32'h8000_8000, 32'h8000_8000);
      check("R7 power sum wraps", result, 64'h8000_0000);

      // R5 squared magnitude: (3 + j4) -> 25
      apply(2'b10, 32'h0004_0003, 32'h0004_0003);
      check("R5 squared magnitude", result, 64'd25);

      // R8 latency: old value holds until the edge, new value after it
      apply(2'b00, 32'd6, 32'd7);
      @(negedge clk);
      mode_sel = 2'b00; src_a = 32'd100; src_b = 32'hFFFF_FFFD;
      #2;
      check("R8 hold before edge", result, 64'd42);
      @(negedge clk);
      check("R8 update after edge", result, 64'hFFFF_FFFF_FFFF_FED4);

      // R9 asynchronous clear mid-run
      #3;
      rst_n = 1'b0;
      #2;
      check("R9 async clear", result, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule